// File: doc/BRIEF.md
# ADC Register Access and Completion Flag

This block is the processor-facing side of a 10-bit analog-to-digital converter inside a small 4-bit controller. The instruction decoder hands it one operation per cycle. It can read nibbles of the conversion result into the A and B accumulators, read or write a 4-bit control register, and load an 8-bit comparator reference. It can also start an operation, or test the completion flag and skip the next instruction. The accumulator values and the skip request come back as registered outputs one cycle after the operation.

Bit 3 of the control register picks the mode. In conversion mode a successive-approximation sequencer finds the result, taking one bit per step-enable pulse, most significant bit first. It drives a trial code to the external analog comparator and reads back the comparator's decision bit. In comparator mode a single step compares the input against the loaded reference and stores the decision in result bit 0. Each mode reads the result through a different nibble window. The completion flag can be consumed in two ways: by a test that skips and clears it, or, when interrupts are enabled, by the interrupt logic acknowledging it.

Top module: `adc_regif`

## Requirements
- R1: After reset the completion flag, busy, skip, both load strobes, both accumulator outputs, the control register, the comparator reference and the result are all zero, so dac_code reads 0.
- R2: Operation code 0 (read high) in conversion mode (control bit 3 = 0) sets b_out = result[9:6] and a_out = result[5:2]. Both a_load and b_load pulse for one cycle, one cycle after the operation.
- R3: Operation code 0 in comparator mode (control bit 3 = 1) sets b_out = result[7:4] and a_out = result[3:0].
- R4: Operation code 1 (read low) sets a_out = {result[1:0], 2'b00}. Only a_load pulses.
- R5: Operation code 6 writes a_in into the 4-bit control register. Operation code 5 returns the register in a_out with a_load. Bit 3 is the mode bit.
- R6: Operation code 2 in comparator mode loads the reference as {b_in, a_in}. In conversion mode the operation is ignored. In comparator mode dac_code = {reference, 2'b00}.
- R7: Operation code 3 in conversion mode clears the flag, raises busy, clears the result and starts from bit 9. On each step_en pulse the bit under trial takes cmp_in. dac_code = result | current trial bit. The tenth step drops busy and sets the flag on the same edge.
- R8: Operation code 3 in comparator mode clears the flag and raises busy. The next step_en pulse stores cmp_in in result bit 0, leaves bits 9..1 unchanged, drops busy and sets the flag.
- R9: A start issued while busy restarts the sequence from bit 9 with a cleared result.
- R10: With irq_en = 0, operation code 4 (test) with the flag at 1 pulses skip one cycle later and clears the flag. With the flag at 0 it gives no skip and leaves the flag at 0.
- R11: With irq_en = 1 the test never skips and leaves the flag set. An irq_ack pulse clears the flag.
- R12: step_en pulses while not busy change neither the result, the flag nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation: 0 read high, 1 read low, 2 load reference, 3 start, 4 test, 5 read control, 6 write control, 7 none |
| a_in | input | 4 | Current A accumulator |
| b_in | input | 4 | Current B accumulator |
| irq_en | input | 1 | Interrupt enable for the completion event |
| irq_ack | input | 1 | Interrupt logic clears the flag |
| step_en | input | 1 | Sequencer step pulse |
| cmp_in | input | 1 | Analog comparator decision (1 = input at or above the trial code) |
| a_out | output | 4 | Value for A |
| b_out | output | 4 | Value for B |
| a_load | output | 1 | Write a_out into A |
| b_load | output | 1 | Write b_out into B |
| skip | output | 1 | Skip the next instruction |
| done_flag | output | 1 | Completion flag |
| busy | output | 1 | Sequencer running |
| dac_code | output | 10 | Trial code for the analog comparator |

## Verification
The hardest cases to reach are the restart and the tenth step of a running conversion. Reaching them needs a start in the middle of a partial approximation, and then exactly ten step pulses with a comparator answer that tracks the trial code. The bench models the analog input as a number and drives cmp_in from a comparison of that number with dac_code. A correct sequence therefore converges to the modelled input. The bench can also stop after three steps to restart, or after nine steps to confirm that the flag has not yet been set.

// File: rtl/adc_regif_pkg.sv
// Package: operation encoding shared by the decoder-facing ADC interface.
package adc_regif_pkg;
    typedef enum logic [2:0] {
        OP_RD_HI  = 3'd0,
        OP_RD_LO  = 3'd1,
        OP_LD_CMP = 3'd2,
        OP_START  = 3'd3,
        OP_TEST   = 3'd4,
        OP_RD_CTL = 3'd5,
        OP_WR_CTL = 3'd6,
        OP_NOP    = 3'd7
    } adc_op_e;
endpackage

// File: rtl/adc_ctl_reg.sv
// Module: adc_ctl_reg
// Holds the nibble-wide ADC control register written from the A accumulator.
// Assumes wr_en is a single-cycle decode of the write-control operation.
module adc_ctl_reg #(
    parameter int NIB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [NIB-1:0] wr_data,
    output logic [NIB-1:0] ctl_q
);
    // Register update on a write operation.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data;
    end

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_q == $past(wr_data)); // R5
endmodule

// File: rtl/adc_sar_seq.sv
// Module: adc_sar_seq
// Successive-approximation sequencer and result register. Conversion mode
// resolves one bit per step pulse from the MSB down. Comparator mode takes
// one step and stores the decision in bit 0. Assumes cmp_in answers the
// dac_code presented in the same cycle.
module adc_sar_seq #(
    parameter int RES_W = 10,
    parameter int CMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic             step_en,
    input  logic             cmp_in,
    input  logic [CMP_W-1:0] cmp_ref,
    output logic [RES_W-1:0] res_q,
    output logic             busy_q,
    output logic             done,
    output logic [RES_W-1:0] dac_code
);
    localparam int PAD_W = RES_W - CMP_W;
    localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] mask_q;
    logic             cmp_run_q;

    // Final step of the running operation.
    assign done = busy_q & step_en & (cmp_run_q | mask_q[0]);

    // Trial code: reference in comparator mode, partial result plus trial bit otherwise.
    assign dac_code = mode ? {cmp_ref, {PAD_W{1'b0}}} : (res_q | mask_q);

    // Sequencer state: start/restart, then one bit per step pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            mask_q    <= '0;
            busy_q    <= 1'b0;
            cmp_run_q <= 1'b0;
        end else if (start) begin
            busy_q    <= 1'b1;
            cmp_run_q <= mode;
            mask_q    <= mode ? '0 : MSB_MASK;
            if (!mode) res_q <= '0;
        end else if (busy_q && step_en) begin
            if (cmp_run_q) begin
                res_q[0] <= cmp_in;
                busy_q   <= 1'b0;
            end else begin
                res_q  <= cmp_in ? (res_q | mask_q) : (res_q & ~mask_q);
                mask_q <= mask_q >> 1;
                if (mask_q[0]) busy_q <= 1'b0;
            end
        end
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy_q); // R7
    AST_CMP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmp_run_q && !start) |=> res_q[RES_W-1:1] == $past(res_q[RES_W-1:1])); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> $stable(res_q)); // R12
endmodule

// File: rtl/adc_flag.sv
// Module: adc_flag
// Completion flag with test-and-skip. Start clears it, completion sets it.
// A test with interrupts disabled consumes it. An interrupt acknowledge
// clears it otherwise. Assumes start and test never coincide.
module adc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic test,
    input  logic irq_en,
    input  logic irq_ack,
    output logic flag_q,
    output logic skip_q
);
    logic test_hit;
    assign test_hit = test & ~irq_en & flag_q;

    // Flag priority: start, completion, consuming test, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (start)    flag_q <= 1'b0;
        else if (done)     flag_q <= 1'b1;
        else if (test_hit) flag_q <= 1'b0;
        else if (irq_ack)  flag_q <= 1'b0;
    end

    // Registered skip request for the instruction decoder.
    always_ff @(posedge clk) begin
        if (!rst_n) skip_q <= 1'b0;
        else        skip_q <= test_hit;
    end

    AST_TEST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (test && !irq_en && flag_q && !start && !done) |=> (!flag_q && skip_q)); // R10
    AST_NO_SKIP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (test && irq_en) |=> !skip_q); // R11
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !flag_q); // R7
endmodule

// File: rtl/adc_read_port.sv
// Module: adc_read_port
// Registers the nibble views returned to the A and B accumulators. The
// read-high window depends on the mode bit. Assumes RES_W - 2*NIB is
// between 1 and NIB.
module adc_read_port
    import adc_regif_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int NIB   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  adc_op_e          op,
    input  logic             mode,
    input  logic [RES_W-1:0] res,
    input  logic [NIB-1:0]   ctl,
    output logic [NIB-1:0]   a_q,
    output logic [NIB-1:0]   b_q,
    output logic             a_ld,
    output logic             b_ld
);
    localparam int LO_W = RES_W - 2*NIB;
    localparam int ZF_W = NIB - LO_W;

    // Capture the selected nibbles and pulse the load strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            a_ld <= 1'b0;
            b_ld <= 1'b0;
        end else begin
            a_ld <= 1'b0;
            b_ld <= 1'b0;
            if (op_valid) begin
                case (op)
                    OP_RD_HI: begin
                        a_ld <= 1'b1;
                        b_ld <= 1'b1;
                        a_q  <= mode ? res[NIB-1:0]       : res[RES_W-NIB-1 -: NIB];
                        b_q  <= mode ? res[2*NIB-1 -: NIB] : res[RES_W-1 -: NIB];
                    end
                    OP_RD_LO: begin
                        a_ld <= 1'b1;
                        a_q  <= {res[LO_W-1:0], {ZF_W{1'b0}}};
                    end
                    OP_RD_CTL: begin
                        a_ld <= 1'b1;
                        a_q  <= ctl;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_LOAD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        b_ld |-> (a_ld && $past(op_valid))); // R2
endmodule

// File: rtl/adc_regif.sv
// Module: adc_regif (top)
// Processor-side ADC register interface: decodes operations, holds the
// comparator reference and ties together the control register, sequencer,
// completion flag and read port. Assumes at most one operation per cycle.
module adc_regif
    import adc_regif_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int NIB   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [NIB-1:0]   a_in,
    input  logic [NIB-1:0]   b_in,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             step_en,
    input  logic             cmp_in,
    output logic [NIB-1:0]   a_out,
    output logic [NIB-1:0]   b_out,
    output logic             a_load,
    output logic             b_load,
    output logic             skip,
    output logic             done_flag,
    output logic             busy,
    output logic [RES_W-1:0] dac_code
);
    localparam int CMP_W    = 2*NIB;
    localparam int MODE_BIT = NIB - 1;

    adc_op_e          op;
    logic [NIB-1:0]   ctl_q;
    logic [CMP_W-1:0] cmp_ref_q;
    logic [RES_W-1:0] res_q;
    logic             mode, do_start, do_test, do_wr_ctl, do_ld_cmp, seq_done;

    // Operation decode.
    assign op        = adc_op_e'(op_code);
    assign mode      = ctl_q[MODE_BIT];
    assign do_start  = op_valid && (op == OP_START);
    assign do_test   = op_valid && (op == OP_TEST);
    assign do_wr_ctl = op_valid && (op == OP_WR_CTL);
    assign do_ld_cmp = op_valid && (op == OP_LD_CMP);

    // Comparator reference: loaded from B:A only in comparator mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                cmp_ref_q <= '0;
        else if (do_ld_cmp && mode) cmp_ref_q <= {b_in, a_in};
    end

    adc_ctl_reg #(.NIB(NIB)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(do_wr_ctl), .wr_data(a_in), .ctl_q(ctl_q)
    );

    adc_sar_seq #(.RES_W(RES_W), .CMP_W(CMP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(do_start), .mode(mode), .step_en(step_en),
        .cmp_in(cmp_in), .cmp_ref(cmp_ref_q), .res_q(res_q), .busy_q(busy),
        .done(seq_done), .dac_code(dac_code)
    );

    adc_flag u_flag (
        .clk(clk), .rst_n(rst_n), .start(do_start), .done(seq_done), .test(do_test),
        .irq_en(irq_en), .irq_ack(irq_ack), .flag_q(done_flag), .skip_q(skip)
    );

    adc_read_port #(.RES_W(RES_W), .NIB(NIB)) u_rd (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .mode(mode),
        .res(res_q), .ctl(ctl_q), .a_q(a_out), .b_q(b_out), .a_ld(a_load), .b_ld(b_load)
    );

    AST_LDCMP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ld_cmp && !mode) |=> $stable(cmp_ref_q)); // R6
    AST_IRQ_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (do_test && irq_en && done_flag && !irq_ack) |=> done_flag); // R11
endmodule

// File: tb/adc_regif_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected accumulator/skip results,
// a monitor pops and compares them in the cycle they appear.
module adc_regif_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd7;
    logic [3:0] a_in = '0, b_in = '0;
    logic       irq_en = 1'b0, irq_ack = 1'b0, step_en = 1'b0;
    logic       cmp_in;
    logic [3:0] a_out, b_out;
    logic       a_load, b_load, skip, done_flag, busy;
    logic [9:0] dac_code;

    logic [9:0] vin = '0;      // modelled analog input
    logic [9:0] m_res = '0;    // expected result register
    logic       m_mode = 1'b0; // expected mode bit
    int         cyc = 0;
    int         errors = 0;
    int         checks = 0;

    typedef struct {
        int         due;
        logic [3:0] a, b;
        logic       al, bl, sk;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk; // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;
    assign cmp_in = (vin >= dac_code);

    adc_regif u_adc_regif (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .a_in(a_in), .b_in(b_in), .irq_en(irq_en), .irq_ack(irq_ack),
        .step_en(step_en), .cmp_in(cmp_in), .a_out(a_out), .b_out(b_out),
        .a_load(a_load), .b_load(b_load), .skip(skip), .done_flag(done_flag),
        .busy(busy), .dac_code(dac_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compare queued expectations in their due cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.req, " a_load"}, a_load, e.al);
            chk({e.req, " b_load"}, b_load, e.bl);
            chk({e.req, " skip"}, skip, e.sk);
            if (e.al) chk({e.req, " a_out"}, a_out, e.a);
            if (e.bl) chk({e.req, " b_out"}, b_out, e.b);
        end
    end

    // Driver: one operation for one cycle, optionally queueing an expectation.
    task automatic do_op(input logic [2:0] code, input logic [3:0] a, input logic [3:0] b,
                         input bit has_exp, input exp_t e);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; a_in = a; b_in = b;
        if (has_exp) begin
            e.due = cyc + 1;
            exp_q.push_back(e);
        end
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd7;
    endtask

    task automatic simple(input logic [2:0] code, input logic [3:0] a, input logic [3:0] b);
        exp_t e;
        e = '{0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, ""};
        do_op(code, a, b, 1'b0, e);
    endtask

    task automatic rd_hi(input string req);
        exp_t e;
        if (m_mode) e = '{0, m_res[3:0], m_res[7:4], 1'b1, 1'b1, 1'b0, req};
        else        e = '{0, m_res[5:2], m_res[9:6], 1'b1, 1'b1, 1'b0, req};
        do_op(3'd0, 4'h0, 4'h0, 1'b1, e);
    endtask

    task automatic rd_lo(input string req);
        exp_t e;
        e = '{0, {m_res[1:0], 2'b00}, 4'h0, 1'b1, 1'b0, 1'b0, req};
        do_op(3'd1, 4'h0, 4'h0, 1'b1, e);
    endtask

    task automatic test_op(input bit exp_skip, input string req);
        exp_t e;
        e = '{0, 4'h0, 4'h0, 1'b0, 1'b0, exp_skip, req};
        do_op(3'd4, 4'h0, 4'h0, 1'b1, e);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); step_en = 1'b1;
            @(negedge clk); step_en = 1'b0;
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 flag", done_flag, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 skip", skip, 1'b0);
        chk("R1 dac_code", dac_code, 10'h000);
        rd_hi("R1 read after reset");

        // R5: control register write/read
        simple(3'd6, 4'h5, 4'h0);
        e = '{0, 4'h5, 4'h0, 1'b1, 1'b0, 1'b0, "R5 read control"};
        do_op(3'd5, 4'h0, 4'h0, 1'b1, e);

        // R7: full conversion
        vin = 10'h2B5;
        simple(3'd3, 4'h0, 4'h0);
        chk("R7 busy after start", busy, 1'b1);
        chk("R7 flag after start", done_flag, 1'b0);
        chk("R7 first trial MSB", dac_code, 10'h200);
        steps(1);
        chk("R7 second trial", dac_code, 10'h300);
        steps(9);
        chk("R7 busy after ten steps", busy, 1'b0);
        chk("R7 flag after ten steps", done_flag, 1'b1);
        m_res = 10'h2B5;
        rd_hi("R2 read high conversion mode");
        rd_lo("R4 read low");

        // R11 then R10: test with and without interrupt enable
        irq_en = 1'b1;
        test_op(1'b0, "R11 test with irq enabled");
        chk("R11 flag kept", done_flag, 1'b1);
        irq_en = 1'b0;
        test_op(1'b1, "R10 test skips");
        chk("R10 flag cleared by test", done_flag, 1'b0);
        test_op(1'b0, "R10 test on clear flag");
        chk("R10 flag stays clear", done_flag, 1'b0);

        // R12: idle step pulses ignored
        vin = 10'h000;
        steps(3);
        chk("R12 busy idle", busy, 1'b0);
        chk("R12 flag idle", done_flag, 1'b0);
        rd_hi("R12 result unchanged");

        // R9: restart mid-conversion
        vin = 10'h3FF;
        simple(3'd3, 4'h0, 4'h0);
        steps(3);
        vin = 10'h156;
        simple(3'd3, 4'h0, 4'h0);
        chk("R9 restart trial MSB", dac_code, 10'h200);
        steps(9);
        chk("R9 busy after nine", busy, 1'b1);
        chk("R9 flag after nine", done_flag, 1'b0);
        steps(1);
        chk("R9 flag after ten", done_flag, 1'b1);
        m_res = 10'h156;
        rd_hi("R9 result after restart");
        rd_lo("R4 read low second value");

        // R6: reference load ignored in conversion mode, taken in comparator mode
        simple(3'd2, 4'hF, 4'hF);
        simple(3'd6, 4'h8, 4'h0);
        m_mode = 1'b1;
        chk("R6 ignored load", dac_code, 10'h000);
        simple(3'd2, 4'h6, 4'h9);
        chk("R6 reference on dac_code", dac_code, 10'h258);
        rd_hi("R3 read high comparator mode");

        // R8: comparator single step
        vin = 10'h300;
        simple(3'd3, 4'h0, 4'h0);
        chk("R8 flag cleared by start", done_flag, 1'b0);
        chk("R8 busy", busy, 1'b1);
        steps(1);
        chk("R8 busy after one step", busy, 1'b0);
        chk("R8 flag set", done_flag, 1'b1);
        m_res = 10'h157;
        rd_hi("R8 decision in bit 0");
        vin = 10'h100;
        simple(3'd3, 4'h0, 4'h0);
        steps(1);
        m_res = 10'h156;
        rd_hi("R3 decision cleared bit 0");

        // R11: acknowledge clears the flag
        chk("R11 flag before ack", done_flag, 1'b1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R11 flag after ack", done_flag, 1'b0);

        repeat (4) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule